// File: doc/BRIEF.md
# Marker Insertion and Ping-Pong Memory Router

This block takes a stream of 16-bit video pixels with a valid qualifier and two end flags (last pixel of a line, last pixel of a frame). It merges them into one continuous word stream in which synchronisation travels in-band. One fixed marker word follows the final pixel of every line, and a second fixed marker word follows the line marker of the final line of every frame. A host that receives the stream can rebuild the picture geometry from these markers alone, with no separate sync wires. Pixel values that happen to equal a marker are clipped, so a marker can never be forged by image content.

The merged stream is steered into one of two memory write ports. At the same time, the read data of the other memory is forwarded to a downstream consumer, so one buffer fills while the other drains. The buffer select is taken only between frames and then held, so a frame never lands in both memories. While a marker is being emitted the block drops its ready output, and the pixel source holds its word until ready returns.

Top module: `stream_mark_router`

## Requirements
- R1: While reset is asserted, both write enables are low, the held buffer select is 0, and the consumer output therefore carries memory 1's read data.
- R2: A pixel accepted at a clock edge (valid and ready both high) appears on the write data of the selected memory, with its write enable high, in the following cycle.
- R3: A pixel whose value is 16'hFF00 or 16'hFF01 is written as 16'hFEFF, and every other pixel value is written unchanged.
- R4: After a pixel flagged as line end, the next output word is the line marker 16'hFF00, and ready is low during the cycle that marker is produced.
- R5: After a pixel flagged as frame end, the line marker 16'hFF00 is written first and the frame marker 16'hFF01 in the cycle after it, and ready is low for both of those cycles. The frame-end flag implies a line end.
- R6: With the held select at 1 the merged stream is written to memory 1; with the held select at 0 it is written to memory 2.
- R7: The consumer output carries memory 2's read data when the held select is 1 and memory 1's read data when it is 0, following read data changes in the same cycle.
- R8: The select input is sampled only while no frame is open. A frame opens with its first accepted pixel and closes after its frame marker, and a select change inside a frame has no effect until then.
- R9: The write enable of the memory that is not selected stays low, and the two write enables are never high together.
- R10: A cycle with valid low and no marker due writes nothing to either memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_vld_i | input | 1 | Pixel word valid |
| pix_data_i | input | 16 | Pixel word |
| pix_eol_i | input | 1 | This pixel is the last of its line |
| pix_eof_i | input | 1 | This pixel is the last of its frame |
| pix_rdy_o | output | 1 | Block can accept a pixel this cycle |
| bank_sel_i | input | 1 | Requested buffer: 1 writes memory 1, 0 writes memory 2 |
| m1_we_o | output | 1 | Memory 1 write enable |
| m1_wdata_o | output | 16 | Memory 1 write data |
| m2_we_o | output | 1 | Memory 2 write enable |
| m2_wdata_o | output | 16 | Memory 2 write data |
| m1_rdata_i | input | 16 | Memory 1 read data |
| m2_rdata_i | input | 16 | Memory 2 read data |
| cons_data_o | output | 16 | Read data forwarded to the downstream consumer |

## Verification
The properties assume a source that follows the valid/ready rule. A word counts as accepted only when ready is high, and the line-end and frame-end flags are meaningful only on accepted words. Under that assumption the checks on marker timing count cycles from acceptance. The stimulus keeps within this by holding the same word and flags steady through every stall cycle, and by changing the buffer select both between frames and in the middle of a frame, so that the hold rule on the select is exercised on both sides.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [1:0] {
    ST_PIX   = 2'd0,
    ST_LMARK = 2'd1,
    ST_FMARK = 2'd2
  } smr_state_e;

  localparam logic [15:0] SMR_LINE_MARK  = 16'hFF00;
  localparam logic [15:0] SMR_FRAME_MARK = 16'hFF01;
  localparam logic [15:0] SMR_CLIP_WORD  = 16'hFEFF;

endpackage

// File: rtl/smr_rst_sync.sv
module smr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/smr_seq.sv
module smr_seq
  import smr_pkg::*;
#(
  parameter int          DW         = 16,
  parameter logic [DW-1:0] LINE_MARK  = SMR_LINE_MARK,
  parameter logic [DW-1:0] FRAME_MARK = SMR_FRAME_MARK,
  parameter logic [DW-1:0] CLIP_WORD  = SMR_CLIP_WORD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_eol_i,
  input  logic          in_eof_i,
  output logic          in_rdy_o,
  input  logic          bank_cur_i,
  output logic          frame_open_o,
  output logic          out_vld_o,
  output logic [DW-1:0] out_word_o,
  output logic          out_bank_o
);

  smr_state_e    state_q, state_d;
  logic          open_q, open_d;
  logic          pend_q, pend_d;
  logic          vld_q, vld_d;
  logic [DW-1:0] word_q, word_d;
  logic          bank_q, bank_d;
  logic [DW-1:0] clipped;

  always_comb begin
    if (in_data_i == LINE_MARK || in_data_i == FRAME_MARK) begin
      clipped = CLIP_WORD;
    end else begin
      clipped = in_data_i;
    end
  end

  assign in_rdy_o = (state_q == ST_PIX);

  always_comb begin
    state_d = state_q;
    open_d  = open_q;
    pend_d  = pend_q;
    vld_d   = 1'b0;
    word_d  = '0;
    bank_d  = bank_cur_i;
    unique case (state_q)
      ST_PIX: begin
        if (in_vld_i) begin
          vld_d  = 1'b1;
          word_d = clipped;
          open_d = 1'b1;
          if (in_eol_i || in_eof_i) begin
            state_d = ST_LMARK;
            pend_d  = in_eof_i;
          end
        end
      end
      ST_LMARK: begin
        vld_d   = 1'b1;
        word_d  = LINE_MARK;
        state_d = pend_q ? ST_FMARK : ST_PIX;
      end
      ST_FMARK: begin
        vld_d   = 1'b1;
        word_d  = FRAME_MARK;
        state_d = ST_PIX;
        open_d  = 1'b0;
        pend_d  = 1'b0;
      end
      default: begin
        state_d = ST_PIX;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PIX;
      open_q  <= 1'b0;
      pend_q  <= 1'b0;
      vld_q   <= 1'b0;
      word_q  <= '0;
      bank_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      open_q  <= open_d;
      pend_q  <= pend_d;
      vld_q   <= vld_d;
      if (vld_d) begin
        word_q <= word_d;
        bank_q <= bank_d;
      end
    end
  end

  assign frame_open_o = open_q;
  assign out_vld_o    = vld_q;
  assign out_word_o   = word_q;
  assign out_bank_o   = bank_q;

endmodule

// File: rtl/smr_bank.sv
module smr_bank (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic hold_i,
  output logic bank_cur_o,
  output logic bank_q_o
);
  logic bank_q;

  assign bank_cur_o = hold_i ? bank_q : sel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
    end else if (!hold_i) begin
      bank_q <= sel_i;
    end
  end

  assign bank_q_o = bank_q;
endmodule

// File: rtl/smr_route.sv
module smr_route #(
  parameter int DW = 16
) (
  input  logic          wr_vld_i,
  input  logic [DW-1:0] wr_word_i,
  input  logic          wr_bank_i,
  input  logic          rd_bank_i,
  input  logic [DW-1:0] rd1_i,
  input  logic [DW-1:0] rd2_i,
  output logic          we1_o,
  output logic [DW-1:0] wd1_o,
  output logic          we2_o,
  output logic [DW-1:0] wd2_o,
  output logic [DW-1:0] cons_o
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] we_vec;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam logic MY_SEL = (g == 0) ? 1'b1 : 1'b0;
    assign we_vec[g] = wr_vld_i && (wr_bank_i == MY_SEL);
  end

  assign we1_o  = we_vec[0];
  assign we2_o  = we_vec[1];
  assign wd1_o  = wr_word_i;
  assign wd2_o  = wr_word_i;
  assign cons_o = rd_bank_i ? rd2_i : rd1_i;
endmodule

// File: rtl/stream_mark_router.sv
module stream_mark_router
  import smr_pkg::*;
#(
  parameter int            DW         = 16,
  parameter logic [DW-1:0] LINE_MARK  = SMR_LINE_MARK,
  parameter logic [DW-1:0] FRAME_MARK = SMR_FRAME_MARK,
  parameter logic [DW-1:0] CLIP_WORD  = SMR_CLIP_WORD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_vld_i,
  input  logic [DW-1:0] pix_data_i,
  input  logic          pix_eol_i,
  input  logic          pix_eof_i,
  output logic          pix_rdy_o,
  input  logic          bank_sel_i,
  output logic          m1_we_o,
  output logic [DW-1:0] m1_wdata_o,
  output logic          m2_we_o,
  output logic [DW-1:0] m2_wdata_o,
  input  logic [DW-1:0] m1_rdata_i,
  input  logic [DW-1:0] m2_rdata_i,
  output logic [DW-1:0] cons_data_o
);

  logic          srst_n;
  logic          frame_open;
  logic          bank_cur;
  logic          bank_held;
  logic          out_vld;
  logic [DW-1:0] out_word;
  logic          out_bank;

  smr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  smr_bank u_bank (
    .clk        (clk),
    .rst_n      (srst_n),
    .sel_i      (bank_sel_i),
    .hold_i     (frame_open),
    .bank_cur_o (bank_cur),
    .bank_q_o   (bank_held)
  );

  smr_seq #(
    .DW         (DW),
    .LINE_MARK  (LINE_MARK),
    .FRAME_MARK (FRAME_MARK),
    .CLIP_WORD  (CLIP_WORD)
  ) u_seq (
    .clk          (clk),
    .rst_n        (srst_n),
    .in_vld_i     (pix_vld_i),
    .in_data_i    (pix_data_i),
    .in_eol_i     (pix_eol_i),
    .in_eof_i     (pix_eof_i),
    .in_rdy_o     (pix_rdy_o),
    .bank_cur_i   (bank_cur),
    .frame_open_o (frame_open),
    .out_vld_o    (out_vld),
    .out_word_o   (out_word),
    .out_bank_o   (out_bank)
  );

  smr_route #(.DW(DW)) u_route (
    .wr_vld_i  (out_vld),
    .wr_word_i (out_word),
    .wr_bank_i (out_bank),
    .rd_bank_i (bank_held),
    .rd1_i     (m1_rdata_i),
    .rd2_i     (m2_rdata_i),
    .we1_o     (m1_we_o),
    .wd1_o     (m1_wdata_o),
    .we2_o     (m2_we_o),
    .wd2_o     (m2_wdata_o),
    .cons_o    (cons_data_o)
  );

endmodule

// File: rtl/stream_mark_router_chk.sv
module stream_mark_router_chk #(
  parameter int            DW         = 16,
  parameter logic [DW-1:0] LINE_MARK  = 16'hFF00,
  parameter logic [DW-1:0] FRAME_MARK = 16'hFF01
) (
  input logic          clk,
  input logic          srst_n,
  input logic          vld,
  input logic          eol,
  input logic          eof,
  input logic          rdy,
  input logic          we1,
  input logic [DW-1:0] wd1,
  input logic          we2,
  input logic [DW-1:0] wd2,
  input logic [DW-1:0] rd1,
  input logic [DW-1:0] rd2,
  input logic [DW-1:0] cons
);
  logic          acc;
  logic          we_any;
  logic [DW-1:0] wd;

  assign acc    = vld && rdy;
  assign we_any = we1 || we2;
  assign wd     = we1 ? wd1 : wd2;

  // R9
  a_r9_single_we: assert property (@(posedge clk) disable iff (!srst_n)
    !(we1 && we2));

  // R2, R3
  a_r3_pixel_not_marker: assert property (@(posedge clk) disable iff (!srst_n)
    acc |=> (we_any && wd != LINE_MARK && wd != FRAME_MARK));

  // R4
  a_r4_line_marker: assert property (@(posedge clk) disable iff (!srst_n)
    (acc && (eol || eof)) |-> ##2 (we_any && wd == LINE_MARK));

  a_r4_stall: assert property (@(posedge clk) disable iff (!srst_n)
    (acc && (eol || eof)) |=> !rdy);

  // R5
  a_r5_frame_marker: assert property (@(posedge clk) disable iff (!srst_n)
    (acc && eof) |-> ##3 (we_any && wd == FRAME_MARK));

  a_r5_stall: assert property (@(posedge clk) disable iff (!srst_n)
    (acc && eof) |-> ##2 !rdy);

  // R8
  a_r8_same_bank: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(we_any) && we_any && $past(wd) != FRAME_MARK) |-> (we1 == $past(we1)));

  // R7
  a_r7_opposite_read: assert property (@(posedge clk) disable iff (!srst_n)
    we_any |-> (cons == (we1 ? rd2 : rd1)));

  // R10
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!srst_n)
    (rdy && !vld) |=> !we_any);

endmodule

bind stream_mark_router stream_mark_router_chk #(
  .DW         (DW),
  .LINE_MARK  (LINE_MARK),
  .FRAME_MARK (FRAME_MARK)
) u_chk (
  .clk    (clk),
  .srst_n (srst_n),
  .vld    (pix_vld_i),
  .eol    (pix_eol_i),
  .eof    (pix_eof_i),
  .rdy    (pix_rdy_o),
  .we1    (m1_we_o),
  .wd1    (m1_wdata_o),
  .we2    (m2_we_o),
  .wd2    (m2_wdata_o),
  .rd1    (m1_rdata_i),
  .rd2    (m2_rdata_i),
  .cons   (cons_data_o)
);

// File: tb/stream_mark_router_test.sv
`timescale 1ns/1ps
module stream_mark_router_test;

  typedef struct packed {
    logic [3:0]  req;
    logic        vld;
    logic        eol;
    logic        eof;
    logic        sel;
    logic [15:0] data;
    logic        we1;
    logic        we2;
    logic [15:0] wdata;
    logic        rdy;
    logic        cons2;
  } vec_t;

  function automatic vec_t mk(input logic [3:0] req, input logic vld, input logic eol,
                              input logic eof, input logic sel, input logic [15:0] data,
                              input logic we1, input logic we2, input logic [15:0] wdata,
                              input logic rdy, input logic cons2);
    vec_t v;
    v.req = req; v.vld = vld; v.eol = eol; v.eof = eof; v.sel = sel; v.data = data;
    v.we1 = we1; v.we2 = we2; v.wdata = wdata; v.rdy = rdy; v.cons2 = cons2;
    return v;
  endfunction

  localparam int NV = 15;
  localparam logic [15:0] RD1 = 16'h1111;
  localparam logic [15:0] RD2 = 16'h2222;

  localparam vec_t TBL [NV] = '{
    mk(4'd10, 0,0,0,1, 16'h0000, 0,0,16'h0000, 1,1), // R10 idle, R8 select taken between frames
    mk(4'd2,  1,0,0,1, 16'h1234, 1,0,16'h1234, 1,1), // R2 R6 pixel into memory 1
    mk(4'd3,  1,0,0,0, 16'hFF00, 1,0,16'hFEFF, 1,1), // R3 clip, R8 select change ignored
    mk(4'd3,  1,1,0,0, 16'hFF01, 1,0,16'hFEFF, 0,1), // R3 clip, R4 stall begins
    mk(4'd4,  1,0,0,0, 16'h5555, 1,0,16'hFF00, 1,1), // R4 line marker, held word not taken
    mk(4'd2,  1,0,0,0, 16'h5555, 1,0,16'h5555, 1,1), // R2 held word accepted
    mk(4'd5,  1,1,1,0, 16'hAAAA, 1,0,16'hAAAA, 0,1), // R5 frame end pixel
    mk(4'd5,  1,0,0,0, 16'h7777, 1,0,16'hFF00, 0,1), // R5 line marker first
    mk(4'd5,  1,0,0,0, 16'h7777, 1,0,16'hFF01, 1,1), // R5 frame marker second
    mk(4'd6,  1,0,0,0, 16'h7777, 0,1,16'h7777, 1,0), // R6 new frame into memory 2, R7
    mk(4'd8,  0,0,0,1, 16'h0000, 0,0,16'h0000, 1,0), // R8 select held while frame open
    mk(4'd3,  1,1,1,1, 16'hFEFF, 0,1,16'hFEFF, 0,0), // R3 clip value passes unchanged
    mk(4'd9,  0,0,0,1, 16'h0000, 0,1,16'hFF00, 0,0), // R9 only memory 2 writes
    mk(4'd5,  0,0,0,1, 16'h0000, 0,1,16'hFF01, 1,0), // R5 frame marker to memory 2
    mk(4'd7,  0,0,0,1, 16'h0000, 0,0,16'h0000, 1,1)  // R7 select taken after frame closes
  };

  logic        clk;
  logic        rst_n;
  logic        pix_vld_i;
  logic [15:0] pix_data_i;
  logic        pix_eol_i;
  logic        pix_eof_i;
  logic        pix_rdy_o;
  logic        bank_sel_i;
  logic        m1_we_o;
  logic [15:0] m1_wdata_o;
  logic        m2_we_o;
  logic [15:0] m2_wdata_o;
  logic [15:0] m1_rdata_i;
  logic [15:0] m2_rdata_i;
  logic [15:0] cons_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  stream_mark_router uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_vld_i   (pix_vld_i),
    .pix_data_i  (pix_data_i),
    .pix_eol_i   (pix_eol_i),
    .pix_eof_i   (pix_eof_i),
    .pix_rdy_o   (pix_rdy_o),
    .bank_sel_i  (bank_sel_i),
    .m1_we_o     (m1_we_o),
    .m1_wdata_o  (m1_wdata_o),
    .m2_we_o     (m2_we_o),
    .m2_wdata_o  (m2_wdata_o),
    .m1_rdata_i  (m1_rdata_i),
    .m2_rdata_i  (m2_rdata_i),
    .cons_data_o (cons_data_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input int req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic l, input logic f, input logic s,
                       input logic [15:0] d);
    pix_vld_i = v; pix_eol_i = l; pix_eof_i = f; bank_sel_i = s; pix_data_i = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    m1_rdata_i = RD1;
    m2_rdata_i = RD2;
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(1, "we1 in reset", {15'd0, m1_we_o}, 16'd0);
    chk(1, "we2 in reset", {15'd0, m2_we_o}, 16'd0);
    chk(1, "consumer in reset", cons_data_o, RD1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].vld, TBL[i].eol, TBL[i].eof, TBL[i].sel, TBL[i].data);
      @(negedge clk);
      chk(TBL[i].req, "we1", {15'd0, m1_we_o}, {15'd0, TBL[i].we1});
      chk(TBL[i].req, "we2", {15'd0, m2_we_o}, {15'd0, TBL[i].we2});
      chk(9, "both enables", {15'd0, m1_we_o & m2_we_o}, 16'd0);
      if (TBL[i].we1) chk(TBL[i].req, "m1 wdata", m1_wdata_o, TBL[i].wdata);
      if (TBL[i].we2) chk(TBL[i].req, "m2 wdata", m2_wdata_o, TBL[i].wdata);
      chk(TBL[i].req, "ready", {15'd0, pix_rdy_o}, {15'd0, TBL[i].rdy});
      chk(7, "consumer", cons_data_o, TBL[i].cons2 ? RD2 : RD1);
    end

    // R7: read data changes follow immediately; held select is 1 here
    m1_rdata_i = 16'h3333;
    #1;
    chk(7, "consumer ignores memory 1", cons_data_o, RD2);
    m2_rdata_i = 16'h4444;
    #1;
    chk(7, "consumer follows memory 2", cons_data_o, 16'h4444);

    // R1: reset in the middle of a frame
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 16'hBEEF);
    @(negedge clk);
    chk(2, "pixel before reset", m1_wdata_o, 16'hBEEF);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    #1 rst_n = 1'b0;
    #1;
    chk(1, "we1 after async reset", {15'd0, m1_we_o}, 16'd0);
    chk(1, "consumer after async reset", cons_data_o, 16'h3333);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 R8: frame reopened after reset uses a fresh select of 0
    drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h0F0F);
    @(negedge clk);
    chk(6, "we2 after reset", {15'd0, m2_we_o}, 16'd1);
    chk(6, "we1 after reset", {15'd0, m1_we_o}, 16'd0);
    chk(2, "m2 wdata after reset", m2_wdata_o, 16'h0F0F);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    chk(10, "no write when idle", {15'd0, m1_we_o | m2_we_o}, 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule